// File: doc/BRIEF.md
# SPI Word FIFO Pair with Level Thresholds

This block holds the two word queues that sit between a register bus and a serial shift engine. Software pushes 32-bit words into the transmit queue and the shift engine pops them one at a time. In the other direction the engine pushes received words into the receive queue and software pops them. Each queue holds eight words.

A configuration word sets a 3-bit threshold for each direction and carries a flush command. The receive ready flag rises when enough words are waiting. The transmit ready flag rises when enough free slots exist. Full and empty flags are reported for both queues. Any push into a full queue or pop from an empty one is recorded in a sticky flag. For a word of N bytes, software normally programs the receive threshold as N-1 and the transmit threshold as 7-N.

Top module: `spi_word_fifos`

## Requirements
- R1: After reset both queues are empty, no flag is full, the sticky flags are clear, all of cfg_rdata is 0, tx_ready is 1 and rx_ready is 0.
- R2: Words pushed by host_push leave through eng_tx_pop in push order. eng_tx_data shows the popped word after the clock edge that samples eng_tx_pop.
- R3: Words pushed by eng_rx_push leave through host_pop in push order. host_rdata shows the popped word after the clock edge that samples host_pop.
- R4: A write with cfg_wr stores the transmit threshold from cfg_wdata[30:28] and the receive threshold from cfg_wdata[26:24]. cfg_rdata returns both thresholds at the same positions and the pending flush at bit 9, and every other bit reads 0.
- R5: rx_ready is 1 exactly when the receive occupancy is greater than the receive threshold.
- R6: tx_ready is 1 exactly when the transmit free space (8 minus occupancy) is greater than the transmit threshold.
- R7: A full flag is 1 when its queue holds 8 words. An empty flag is 1 when its queue holds 0 words. The two are never 1 together.
- R8: A push into a full queue is dropped, and the queue's overflow flag (tx_ovf or rx_ovf) becomes 1 and stays 1 until a flush or reset.
- R9: A pop from an empty queue returns 0 on that queue's data output. The queue's underflow flag (tx_unf or rx_unf) becomes 1 and stays 1 until a flush or reset.
- R10: Writing cfg_wdata bit 9 = 1 sets a pending flush that reads back as 1 until the next clock edge. On that edge both queues are emptied, all sticky flags are cleared, any push or pop in that cycle is ignored, and the thresholds are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration write data: thresholds and flush command |
| cfg_rdata | output | 32 | Configuration readback |
| host_push | input | 1 | Push host_wdata into the transmit queue |
| host_wdata | input | 32 | Word to transmit |
| host_pop | input | 1 | Pop one word from the receive queue |
| host_rdata | output | 32 | Word popped from the receive queue |
| eng_tx_pop | input | 1 | Shift engine takes one word from the transmit queue |
| eng_tx_data | output | 32 | Word taken from the transmit queue |
| eng_rx_push | input | 1 | Shift engine stores eng_rx_data into the receive queue |
| eng_rx_data | input | 32 | Received word |
| tx_full | output | 1 | Transmit queue holds 8 words |
| tx_empty | output | 1 | Transmit queue holds no word |
| tx_ready | output | 1 | Transmit free space above its threshold |
| tx_ovf | output | 1 | Sticky: push into full transmit queue |
| tx_unf | output | 1 | Sticky: pop from empty transmit queue |
| rx_full | output | 1 | Receive queue holds 8 words |
| rx_empty | output | 1 | Receive queue holds no word |
| rx_ready | output | 1 | Receive occupancy above its threshold |
| rx_ovf | output | 1 | Sticky: push into full receive queue |
| rx_unf | output | 1 | Sticky: pop from empty receive queue |

## Verification
The full, empty, ready and sticky flags change on the same clock edge that samples the push or pop. Popped data appears after the edge that samples the pop. A new threshold affects the ready flags one edge after the configuration write. A flush takes effect on the edge after the write that requests it. The bench drives every input on the falling edge and samples one falling edge after the last edge that should have changed the result. The threshold sweep always spends one flush cycle between a configuration write and the first push, so the new threshold is settled before any check.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
  localparam int unsigned CFG_W     = 32;
  localparam int unsigned TX_THR_LSB = 28;
  localparam int unsigned RX_THR_LSB = 24;
  localparam int unsigned FLUSH_BIT  = 9;

  // which level a ready flag is measured against
  typedef enum logic {
    LVL_FILL  = 1'b0,
    LVL_SPACE = 1'b1
  } lvl_kind_e;

  typedef struct packed {
    logic full;
    logic empty;
    logic ready;
    logic ovf;
    logic unf;
  } fifo_flags_t;
endpackage

// File: rtl/word_fifo.sv
module word_fifo #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] pop_data,
  output logic [CW-1:0] cnt_nxt
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic          push_ok, pop_ok;

  assign push_ok = push && !flush && (cnt_q != CW'(DEPTH));
  assign pop_ok  = pop  && !flush && (cnt_q != '0);

  always_comb begin
    if (flush) cnt_nxt = '0;
    else       cnt_nxt = cnt_q + CW'(push_ok) - CW'(pop_ok);
  end

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr_q] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pop_data <= '0;
    end else if (pop_ok) begin
      pop_data <= mem[rptr_q];
    end else if (pop && !flush) begin
      pop_data <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_nxt;
      if (push_ok) wptr_q <= (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
      if (pop_ok)  rptr_q <= (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
    end
  end
endmodule

// File: rtl/fifo_flags.sv
module fifo_flags
  import sfifo_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned TW    = 3,
  parameter lvl_kind_e   KIND  = LVL_FILL,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic          pop,
  input  logic [CW-1:0] cnt_nxt,
  input  logic [TW-1:0] thr,
  output fifo_flags_t   flags_q
);
  localparam logic RST_READY = (KIND == LVL_SPACE);

  logic [CW-1:0] metric;
  logic          ready_nxt;

  if (KIND == LVL_SPACE) begin : g_space
    assign metric = CW'(DEPTH) - cnt_nxt;
  end else begin : g_fill
    assign metric = cnt_nxt;
  end

  assign ready_nxt = (metric > CW'(thr));

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '{full: 1'b0, empty: 1'b1, ready: RST_READY, ovf: 1'b0, unf: 1'b0};
    end else begin
      flags_q.full  <= (cnt_nxt == CW'(DEPTH));
      flags_q.empty <= (cnt_nxt == '0);
      flags_q.ready <= ready_nxt;
      if (flush) begin
        flags_q.ovf <= 1'b0;
        flags_q.unf <= 1'b0;
      end else begin
        flags_q.ovf <= flags_q.ovf | (push & flags_q.full);
        flags_q.unf <= flags_q.unf | (pop & flags_q.empty);
      end
    end
  end
endmodule

// File: rtl/spi_word_fifos.sv
module spi_word_fifos
  import sfifo_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 8,
  parameter int unsigned TW    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic             host_push,
  input  logic [DW-1:0]    host_wdata,
  input  logic             host_pop,
  output logic [DW-1:0]    host_rdata,
  input  logic             eng_tx_pop,
  output logic [DW-1:0]    eng_tx_data,
  input  logic             eng_rx_push,
  input  logic [DW-1:0]    eng_rx_data,
  output logic             tx_full,
  output logic             tx_empty,
  output logic             tx_ready,
  output logic             tx_ovf,
  output logic             tx_unf,
  output logic             rx_full,
  output logic             rx_empty,
  output logic             rx_ready,
  output logic             rx_ovf,
  output logic             rx_unf
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [TW-1:0] tx_thr_q, rx_thr_q;
  logic          flush_q;
  logic          unused_cfg;
  logic [CW-1:0] tx_cnt_nxt, rx_cnt_nxt;
  fifo_flags_t   tx_fl, rx_fl;

  assign unused_cfg = ^cfg_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_thr_q <= '0;
      rx_thr_q <= '0;
      flush_q  <= 1'b0;
    end else begin
      flush_q <= cfg_wr && cfg_wdata[FLUSH_BIT];
      if (cfg_wr) begin
        tx_thr_q <= cfg_wdata[TX_THR_LSB +: TW];
        rx_thr_q <= cfg_wdata[RX_THR_LSB +: TW];
      end
    end
  end

  always_comb begin
    cfg_rdata                    = '0;
    cfg_rdata[TX_THR_LSB +: TW]  = tx_thr_q;
    cfg_rdata[RX_THR_LSB +: TW]  = rx_thr_q;
    cfg_rdata[FLUSH_BIT]         = flush_q;
  end

  word_fifo #(.DW(DW), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .flush(flush_q),
    .push(host_push), .push_data(host_wdata),
    .pop(eng_tx_pop), .pop_data(eng_tx_data),
    .cnt_nxt(tx_cnt_nxt)
  );

  fifo_flags #(.DEPTH(DEPTH), .TW(TW), .KIND(LVL_SPACE)) u_txf (
    .clk(clk), .rst(rst), .flush(flush_q),
    .push(host_push), .pop(eng_tx_pop),
    .cnt_nxt(tx_cnt_nxt), .thr(tx_thr_q), .flags_q(tx_fl)
  );

  word_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .flush(flush_q),
    .push(eng_rx_push), .push_data(eng_rx_data),
    .pop(host_pop), .pop_data(host_rdata),
    .cnt_nxt(rx_cnt_nxt)
  );

  fifo_flags #(.DEPTH(DEPTH), .TW(TW), .KIND(LVL_FILL)) u_rxf (
    .clk(clk), .rst(rst), .flush(flush_q),
    .push(eng_rx_push), .pop(host_pop),
    .cnt_nxt(rx_cnt_nxt), .thr(rx_thr_q), .flags_q(rx_fl)
  );

  assign tx_full  = tx_fl.full;
  assign tx_empty = tx_fl.empty;
  assign tx_ready = tx_fl.ready;
  assign tx_ovf   = tx_fl.ovf;
  assign tx_unf   = tx_fl.unf;
  assign rx_full  = rx_fl.full;
  assign rx_empty = rx_fl.empty;
  assign rx_ready = rx_fl.ready;
  assign rx_ovf   = rx_fl.ovf;
  assign rx_unf   = rx_fl.unf;
endmodule

// File: rtl/spi_word_fifos_chk.sv
module spi_word_fifos_chk #(
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic [31:0]   cfg_rdata,
  input logic          host_push,
  input logic          host_pop,
  input logic [DW-1:0] host_rdata,
  input logic          tx_full,
  input logic          tx_empty,
  input logic          tx_ready,
  input logic          tx_ovf,
  input logic          tx_unf,
  input logic          rx_full,
  input logic          rx_empty,
  input logic          rx_ready,
  input logic          rx_ovf,
  input logic          rx_unf
);
  logic fl_pend;
  assign fl_pend = cfg_rdata[sfifo_pkg::FLUSH_BIT];

  // R7: a queue cannot be full and empty at once
  a_r7_tx_excl: assert property (@(posedge clk) disable iff (rst) !(tx_full && tx_empty));
  a_r7_rx_excl: assert property (@(posedge clk) disable iff (rst) !(rx_full && rx_empty));

  // R5: eight waiting words exceed every 3-bit threshold
  a_r5_full_ready: assert property (@(posedge clk) disable iff (rst) rx_full |-> rx_ready);

  // R6: eight free slots exceed every 3-bit threshold
  a_r6_empty_ready: assert property (@(posedge clk) disable iff (rst) tx_empty |-> tx_ready);

  // R8: overflow only rises after a push into a full queue, then holds
  a_r8_ovf_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_ovf) |-> $past(host_push && tx_full && !fl_pend));
  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    (tx_ovf && !fl_pend) |=> tx_ovf);

  // R9: pop from empty receive queue yields zero data
  a_r9_unf_zero: assert property (@(posedge clk) disable iff (rst)
    (host_pop && rx_empty && !fl_pend) |=> (host_rdata == '0 && rx_unf));

  // R10: pending flush clears queues and sticky flags on the next edge
  a_r10_flush_clears: assert property (@(posedge clk) disable iff (rst)
    fl_pend |=> (tx_empty && rx_empty && !tx_ovf && !tx_unf && !rx_ovf && !rx_unf));
endmodule

bind spi_word_fifos spi_word_fifos_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .cfg_rdata(cfg_rdata),
  .host_push(host_push), .host_pop(host_pop), .host_rdata(host_rdata),
  .tx_full(tx_full), .tx_empty(tx_empty), .tx_ready(tx_ready),
  .tx_ovf(tx_ovf), .tx_unf(tx_unf),
  .rx_full(rx_full), .rx_empty(rx_empty), .rx_ready(rx_ready),
  .rx_ovf(rx_ovf), .rx_unf(rx_unf)
);

// File: tb/tb_spi_word_fifos.sv
module tb_spi_word_fifos;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        host_push = 1'b0, host_pop = 1'b0;
  logic [31:0] host_wdata = '0, host_rdata;
  logic        eng_tx_pop = 1'b0, eng_rx_push = 1'b0;
  logic [31:0] eng_tx_data, eng_rx_data = '0;
  logic        tx_full, tx_empty, tx_ready, tx_ovf, tx_unf;
  logic        rx_full, rx_empty, rx_ready, rx_ovf, rx_unf;

  int nchk = 0;
  int nbad = 0;
  bit ended = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_word_fifos dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .host_push(host_push), .host_wdata(host_wdata), .host_pop(host_pop), .host_rdata(host_rdata),
    .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data),
    .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
    .tx_full(tx_full), .tx_empty(tx_empty), .tx_ready(tx_ready), .tx_ovf(tx_ovf), .tx_unf(tx_unf),
    .rx_full(rx_full), .rx_empty(rx_empty), .rx_ready(rx_ready), .rx_ovf(rx_ovf), .rx_unf(rx_unf)
  );

  // {tx_thr, rx_thr, words, exp rx_ready, exp tx_ready, exp full, exp empty}
  localparam logic [13:0] VEC [8] = '{
    {3'd0, 3'd0, 4'd0, 4'b0101},
    {3'd0, 3'd0, 4'd1, 4'b1100},
    {3'd3, 3'd3, 4'd3, 4'b0100},
    {3'd3, 3'd3, 4'd4, 4'b1100},
    {3'd3, 3'd3, 4'd5, 4'b1000},
    {3'd7, 3'd7, 4'd7, 4'b0000},
    {3'd0, 3'd7, 4'd8, 4'b1010},
    {3'd6, 3'd0, 4'd6, 4'b1000}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cfg_write(input logic [31:0] w);
    cfg_wdata = w;
    cfg_wr = 1'b1;
    tick();
    cfg_wr = 1'b0;
    cfg_wdata = '0;
  endtask

  function automatic logic [31:0] cfg_word(input logic [2:0] txt, input logic [2:0] rxt, input logic fl);
    logic [31:0] w = '0;
    w[30:28] = txt;
    w[26:24] = rxt;
    w[9] = fl;
    return w;
  endfunction

  task automatic flush_with(input logic [2:0] txt, input logic [2:0] rxt);
    cfg_write(cfg_word(txt, rxt, 1'b1));
    tick();
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nbad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    @(negedge clk);
    repeat (3) tick();
    rst = 1'b0;
    tick();

    // R1 reset state
    check("R1 cfg_rdata", cfg_rdata, 32'h0);
    check("R1 flags", {27'd0, tx_full, tx_empty, tx_ready, tx_ovf, tx_unf}, 32'h0000_000C);
    check("R1 rx flags", {27'd0, rx_full, rx_empty, rx_ready, rx_ovf, rx_unf}, 32'h0000_0008);

    // R5 R6 R7 threshold sweep from the table
    for (int i = 0; i < 8; i++) begin
      flush_with(VEC[i][13:11], VEC[i][10:8]);
      for (int k = 0; k < int'(VEC[i][7:4]); k++) begin
        host_push = 1'b1; host_wdata = 32'h1000 + k;
        eng_rx_push = 1'b1; eng_rx_data = 32'h2000 + k;
        tick();
      end
      host_push = 1'b0; eng_rx_push = 1'b0;
      check("R5 rx_ready", {31'd0, rx_ready}, {31'd0, VEC[i][3]});
      check("R6 tx_ready", {31'd0, tx_ready}, {31'd0, VEC[i][2]});
      check("R7 full/empty", {28'd0, tx_full, rx_full, tx_empty, rx_empty},
            {28'd0, VEC[i][1], VEC[i][1], VEC[i][0], VEC[i][0]});
    end

    // R2 transmit order
    flush_with(3'd0, 3'd0);
    for (int k = 0; k < 3; k++) begin
      host_push = 1'b1; host_wdata = 32'hA0A0_0000 + k;
      tick();
    end
    host_push = 1'b0;
    for (int k = 0; k < 3; k++) begin
      eng_tx_pop = 1'b1;
      tick();
      check("R2 tx order", eng_tx_data, 32'hA0A0_0000 + k);
    end
    eng_tx_pop = 1'b0;
    check("R7 tx empty after drain", {31'd0, tx_empty}, 32'd1);

    // R3 receive order
    for (int k = 0; k < 3; k++) begin
      eng_rx_push = 1'b1; eng_rx_data = 32'hB0B0_0000 + k;
      tick();
    end
    eng_rx_push = 1'b0;
    for (int k = 0; k < 3; k++) begin
      host_pop = 1'b1;
      tick();
      check("R3 rx order", host_rdata, 32'hB0B0_0000 + k);
    end
    host_pop = 1'b0;

    // R9 underflow on both queues
    host_pop = 1'b1;
    tick();
    host_pop = 1'b0;
    check("R9 rx pop empty data", host_rdata, 32'h0);
    check("R9 rx_unf set", {31'd0, rx_unf}, 32'd1);
    eng_tx_pop = 1'b1;
    tick();
    eng_tx_pop = 1'b0;
    check("R9 tx pop empty data", eng_tx_data, 32'h0);
    tick(); tick();
    check("R9 sticky underflows", {30'd0, tx_unf, rx_unf}, 32'd3);

    // R4 R10 flush readback and clearing
    cfg_write(32'hFFFF_FFFF);
    check("R4 R10 readback pending", cfg_rdata, 32'h7700_0200);
    host_push = 1'b1; host_wdata = 32'h5555_5555;
    tick();
    host_push = 1'b0;
    check("R10 flush done", cfg_rdata, 32'h7700_0000);
    check("R10 push in flush cycle ignored", {31'd0, tx_empty}, 32'd1);
    check("R10 stickies cleared", {28'd0, tx_ovf, tx_unf, rx_ovf, rx_unf}, 32'd0);
    cfg_write(cfg_word(3'd2, 3'd5, 1'b0));
    check("R4 thresholds stored", cfg_rdata, 32'h2500_0000);

    // R8 overflow on transmit queue
    flush_with(3'd0, 3'd0);
    for (int k = 0; k < 9; k++) begin
      host_push = 1'b1; host_wdata = 32'hC000 + k;
      tick();
      if (k == 7) check("R7 tx full at 8", {30'd0, tx_full, tx_ovf}, 32'd2);
    end
    host_push = 1'b0;
    check("R8 tx_ovf set", {31'd0, tx_ovf}, 32'd1);
    for (int k = 0; k < 8; k++) begin
      eng_tx_pop = 1'b1;
      tick();
      check("R8 kept words", eng_tx_data, 32'hC000 + k);
    end
    eng_tx_pop = 1'b1;
    tick();
    eng_tx_pop = 1'b0;
    check("R8 dropped word absent", eng_tx_data, 32'h0);
    check("R8 tx_ovf sticky", {31'd0, tx_ovf}, 32'd1);

    // R8 overflow on receive queue
    for (int k = 0; k < 9; k++) begin
      eng_rx_push = 1'b1; eng_rx_data = 32'hD000 + k;
      tick();
    end
    eng_rx_push = 1'b0;
    check("R8 rx_ovf set", {30'd0, rx_ovf, rx_full}, 32'd3);

    finish_run();
  end
endmodule